// File: doc/BRIEF.md
# Mode-selectable 8/16-bit IRQ cycle counter

This block raises an interrupt after a programmable number of CPU clocks on a cartridge board. The CPU programs it with plain bus writes; the upper three bits of the write address, `wr_addr[14:12]`, pick the target register. A 16-bit reload value is assembled four bits at a time. A control write then sets the counting width and the enable. Once enabled, the counter steps up by one on every clock. When the counted part rolls over to zero, the interrupt line goes high and the counted part is reloaded from the reload value.

The counting width is either the full 16 bits or only the low 8 bits. In the narrow setting the upper byte of the count is frozen, so the interrupt period is set by the low byte of the reload value alone. An acknowledge write drops the interrupt and can stop or keep the counter, as chosen at the last control write. The block also holds a 3-bit number that selects a 16 KB program bank; decoding that number into memory is done elsewhere.

Top module: `irq_cycle_counter`

## Requirements
- R1: A write with `wr_addr[14:12]` in 0..3 stores `wr_data[3:0]` into bits [4k+3:4k] of the 16-bit reload value, where k = `wr_addr[13:12]`. Such a write does not disturb a running count, and the new value is used at the next reload.
- R2: A write with `wr_addr[14:12]`=4 is a control write. `wr_data[2]` selects the width (1 = 8-bit, 0 = 16-bit), `wr_data[1]` enables counting, and `wr_data[0]` is the enable that is applied on acknowledge. With the enable bit 0, the counter stops.
- R3: A control write with `wr_data[1]`=1 loads all 16 counter bits from the reload value. Every control write drives `irq_o` low on the following cycle. No count step takes place in the cycle of a control write.
- R4: In 16-bit mode with counting enabled, the count rises by one each clock. When it wraps to 0, `irq_o` rises and the count is reloaded. After a load from reload value L, `irq_o` rises on the (0x10000-L)-th clock edge.
- R5: In 8-bit mode only bits [7:0] count and reload, and bits [15:8] hold their value. After a load from L, `irq_o` rises on the (0x100-L[7:0])-th edge and then repeats with that same period.
- R6: A write with `wr_addr[14:12]`=5 is an acknowledge. It clears `irq_o` and sets the enable to the stored enable-on-acknowledge value. A running count continues from its current value.
- R7: If an acknowledge falls in the same cycle as a wrap, the wrap wins and `irq_o` stays high.
- R8: Once high, `irq_o` stays high until a control or acknowledge write clears it.
- R9: A write with `wr_addr[14:12]`=7 sets `prg_bank_o` to `wr_data[2:0]`. A write with `wr_addr[14:12]`=6 has no effect on any output.
- R10: While `rst` is high, the reload value, count, mode, enables, `irq_o` and `prg_bank_o` are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one count step per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 15 | Write address within the upper window; bits [14:12] select the register |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Interrupt request, registered, held until cleared |
| prg_bank_o | output | 3 | Selected 16 KB program bank |

## Verification
Two things can fall in the same clock: a count step that rolls the counted part over to zero, and an acknowledge write. The bench arms a short period and places the acknowledge exactly on the wrap edge. It expects `irq_o` to stay high there. It then expects `irq_o` to drop for an acknowledge one cycle later, and to rise again after a full period from the reload. Random phases mix writes of every kind with continuous counting, so these collisions also arise without being planned, and a cycle-level model of the requirements judges each cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_NIB0  = 3'd0,
    SEL_NIB1  = 3'd1,
    SEL_NIB2  = 3'd2,
    SEL_NIB3  = 3'd3,
    SEL_CTRL  = 3'd4,
    SEL_ACK   = 3'd5,
    SEL_SPARE = 3'd6,
    SEL_BANK  = 3'd7
  } reg_sel_e;

  // control data bit positions
  localparam int CTRL_SHORT_BIT = 2;
  localparam int CTRL_RUN_BIT   = 1;
  localparam int CTRL_REARM_BIT = 0;

  typedef struct packed {
    logic short_mode;
    logic run;
    logic run_after_ack;
  } ctrl_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int NUM_NIB = 4
) (
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   sel_bits,
  output logic [NUM_NIB-1:0] nib_we,
  output logic               ctrl_we,
  output logic               ack_we,
  output logic               bank_we
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_bits);

  for (genvar g = 0; g < NUM_NIB; g++) begin : g_nib
    assign nib_we[g] = wr_en && (sel == reg_sel_e'(SEL_W'(g)));
  end

  assign ctrl_we = wr_en && (sel == SEL_CTRL);
  assign ack_we  = wr_en && (sel == SEL_ACK);
  assign bank_we = wr_en && (sel == SEL_BANK);

endmodule

// File: rtl/irqc_reload_latch.sv
module irqc_reload_latch #(
  parameter int CNT_W = 16,
  parameter int NIB_W = 4,
  localparam int NUM_NIB = CNT_W / NIB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_NIB-1:0] nib_we,
  input  logic [NIB_W-1:0]   nib_data,
  output logic [CNT_W-1:0]   latch_o
);

  logic [CNT_W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else begin
      for (int i = 0; i < NUM_NIB; i++) begin
        if (nib_we[i]) latch_q[i*NIB_W +: NIB_W] <= nib_data;
      end
    end
  end

  assign latch_o = latch_q;

endmodule

// File: rtl/irqc_counter.sv
module irqc_counter
  import irqc_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  ctrl_t            ctrl_in,
  input  logic             ack_we,
  input  logic [CNT_W-1:0] latch_i,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] SHORT_MASK = {{(CNT_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
  localparam logic [CNT_W-1:0] FULL_MASK  = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             short_q, run_q, rearm_q, irq_q;

  logic [CNT_W-1:0] mask, inc_masked, stepped;
  logic             wrap;

  always_comb begin
    mask       = short_q ? SHORT_MASK : FULL_MASK;
    inc_masked = (cnt_q + 1'b1) & mask;
    wrap       = run_q && (inc_masked == '0);
    stepped    = (cnt_q & ~mask) | (wrap ? (latch_i & mask) : inc_masked);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
      run_q   <= 1'b0;
      rearm_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (ctrl_we) begin
      short_q <= ctrl_in.short_mode;
      run_q   <= ctrl_in.run;
      rearm_q <= ctrl_in.run_after_ack;
      if (ctrl_in.run) cnt_q <= latch_i;
      irq_q   <= 1'b0;
    end else begin
      if (run_q) cnt_q <= stepped;
      if (wrap)        irq_q <= 1'b1;
      else if (ack_we) irq_q <= 1'b0;
      if (ack_we) run_q <= rearm_q;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_cycle_counter.sv
module irq_cycle_counter
  import irqc_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 16,
  parameter int SHORT_W = 8,
  parameter int NIB_W   = 4,
  parameter int BANK_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq_o,
  output logic [BANK_W-1:0] prg_bank_o
);

  localparam int NUM_NIB = CNT_W / NIB_W;

  logic [NUM_NIB-1:0] nib_we;
  logic               ctrl_we, ack_we, bank_we;
  logic [CNT_W-1:0]   latch_val;
  ctrl_t              ctrl_fields;
  logic [BANK_W-1:0]  bank_q;

  logic unused_bits;
  assign unused_bits = ^{wr_addr[ADDR_W-SEL_W-1:0], wr_data[DATA_W-1:NIB_W]};

  irqc_decode #(.NUM_NIB(NUM_NIB)) u_decode (
    .wr_en    (wr_en),
    .sel_bits (wr_addr[ADDR_W-1 -: SEL_W]),
    .nib_we   (nib_we),
    .ctrl_we  (ctrl_we),
    .ack_we   (ack_we),
    .bank_we  (bank_we)
  );

  irqc_reload_latch #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .nib_we   (nib_we),
    .nib_data (wr_data[NIB_W-1:0]),
    .latch_o  (latch_val)
  );

  assign ctrl_fields = '{short_mode:    wr_data[CTRL_SHORT_BIT],
                         run:           wr_data[CTRL_RUN_BIT],
                         run_after_ack: wr_data[CTRL_REARM_BIT]};

  irqc_counter #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .ctrl_we (ctrl_we),
    .ctrl_in (ctrl_fields),
    .ack_we  (ack_we),
    .latch_i (latch_val),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          bank_q <= '0;
    else if (bank_we) bank_q <= wr_data[BANK_W-1:0];
  end

  assign prg_bank_o = bank_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int BANK_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [2:0]        sel,
  input logic [BANK_W-1:0] bank_data,
  input logic              irq_o,
  input logic [BANK_W-1:0] prg_bank_o
);

  AST_CTRL_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == 3'd4) |=> !irq_o);  // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !(wr_en && (sel == 3'd4 || sel == 3'd5))) |=> irq_o);  // R8

  AST_NO_RISE_AFTER_CTRL: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> !$past(wr_en && sel == 3'd4));  // R3

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == 3'd7) |=> (prg_bank_o == $past(bank_data)));  // R9

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sel == 3'd7) |=> $stable(prg_bank_o));  // R9

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!irq_o && prg_bank_o == '0));  // R10

endmodule

bind irq_cycle_counter irqc_checker #(.BANK_W(BANK_W)) u_irqc_checker (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .sel        (wr_addr[ADDR_W-1 -: 3]),
  .bank_data  (wr_data[BANK_W-1:0]),
  .irq_o      (irq_o),
  .prg_bank_o (prg_bank_o)
);

// File: tb/irq_cycle_counter_bench.sv
module irq_cycle_counter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq_o;
  logic [2:0]  prg_bank_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_cycle_counter u_irq_cycle_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_o(irq_o), .prg_bank_o(prg_bank_o)
  );

  // cycle model built from the requirements, used in random phases
  logic [15:0] m_cnt, m_latch;
  logic        m_short, m_run, m_rearm, m_irq;
  logic [2:0]  m_bank;

  always @(posedge clk) begin
    logic [15:0] mk, inc, nx;
    logic        is_ctrl, is_ack, wrp;
    if (rst) begin
      m_cnt <= '0; m_latch <= '0; m_short <= 1'b0; m_run <= 1'b0;
      m_rearm <= 1'b0; m_irq <= 1'b0; m_bank <= '0;
    end else begin
      mk      = m_short ? 16'h00FF : 16'hFFFF;
      is_ctrl = wr_en && wr_addr[14:12] == 3'd4;
      is_ack  = wr_en && wr_addr[14:12] == 3'd5;
      if (is_ctrl) begin
        m_short <= wr_data[2];
        m_run   <= wr_data[1];
        m_rearm <= wr_data[0];
        if (wr_data[1]) m_cnt <= m_latch;
        m_irq   <= 1'b0;
      end else begin
        wrp = 1'b0;
        if (m_run) begin
          inc = (m_cnt + 16'd1) & mk;
          if (inc == 16'd0) begin
            wrp = 1'b1;
            nx  = (m_cnt & ~mk) | (m_latch & mk);
          end else begin
            nx  = (m_cnt & ~mk) | inc;
          end
          m_cnt <= nx;
        end
        if (wrp)         m_irq <= 1'b1;
        else if (is_ack) m_irq <= 1'b0;
        if (is_ack) m_run <= m_rearm;
      end
      if (wr_en && !wr_addr[14]) m_latch[4*wr_addr[13:12] +: 4] <= wr_data[3:0];
      if (wr_en && wr_addr[14:12] == 3'd7) m_bank <= wr_data[2:0];
    end
  end

  task automatic check_irq(string tag, logic exp);
    n_checks++;
    if (irq_o !== exp) begin
      n_errors++;
      $display("FAIL %s: irq_o actual=%0b expected=%0b at %0t", tag, irq_o, exp, $time);
    end
  endtask

  task automatic check_bank(string tag, logic [2:0] exp);
    n_checks++;
    if (prg_bank_o !== exp) begin
      n_errors++;
      $display("FAIL %s: prg_bank_o actual=%0d expected=%0d at %0t", tag, prg_bank_o, exp, $time);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic do_write(logic [2:0] sel, logic [11:0] low, logic [7:0] d);
    wr_en   = 1'b1;
    wr_addr = {sel, low};
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic edges(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic load_latch(logic [15:0] v);
    do_write(3'd0, 12'hABC, {4'h9, v[3:0]});
    do_write(3'd1, 12'h001, {4'h6, v[7:4]});
    do_write(3'd2, 12'hFFF, {4'h3, v[11:8]});
    do_write(3'd3, 12'h040, {4'hC, v[15:12]});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_irq("R10 irq in reset", 1'b0);
    check_bank("R10 bank in reset", 3'd0);
    rst = 1'b0;
    edges(2);
    check_irq("R10 irq after reset", 1'b0);

    // R9 bank select and spare address
    do_write(3'd7, 12'h123, 8'hFD);
    check_bank("R9 bank from data[2:0]", 3'd5);
    do_write(3'd6, 12'h000, 8'hFF);
    check_bank("R9 spare write ignored", 3'd5);
    do_write(3'd7, 12'h000, 8'h02);
    check_bank("R9 bank rewrite", 3'd2);

    // R4 16-bit period from 0xFFFA = 6 edges
    load_latch(16'hFFFA);
    do_write(3'd4, 12'h000, 8'h02);
    check_irq("R3 ctrl write irq low", 1'b0);
    edges(5);
    check_irq("R4 before wrap", 1'b0);
    edges(1);
    check_irq("R4 wrap raises irq", 1'b1);
    edges(10);
    check_irq("R8 irq held", 1'b1);
    do_write(3'd6, 12'h555, 8'hFF);
    check_irq("R8 spare write keeps irq", 1'b1);
    check_bank("R9 spare write keeps bank", 3'd2);
    edges(1);
    do_write(3'd5, 12'h000, 8'h00);
    check_irq("R6 ack clears irq", 1'b0);
    edges(20);
    check_irq("R6 enable from ack value 0 stops counting", 1'b0);

    // R5 8-bit mode, latch 0x12FC => 4 edges
    load_latch(16'h12FC);
    do_write(3'd4, 12'h000, 8'h07);
    edges(3);
    check_irq("R5 before short wrap", 1'b0);
    edges(1);
    check_irq("R5 short wrap raises irq", 1'b1);
    do_write(3'd5, 12'h000, 8'h00);
    check_irq("R6 ack clears irq, keeps running", 1'b0);
    edges(2);
    check_irq("R6 continues from current count", 1'b0);
    edges(1);
    check_irq("R5 short period repeats", 1'b1);

    // R7 ack on the wrap edge
    load_latch(16'hFFFA);
    do_write(3'd4, 12'h000, 8'h03);
    check_irq("R3 ctrl write clears irq", 1'b0);
    edges(5);
    do_write(3'd5, 12'h000, 8'h00);
    check_irq("R7 wrap beats ack", 1'b1);
    do_write(3'd5, 12'h000, 8'h00);
    check_irq("R6 ack one cycle later clears", 1'b0);
    edges(4);
    check_irq("R7 reload period before", 1'b0);
    edges(1);
    check_irq("R7 reload period wrap", 1'b1);

    // R2 width bit: latch 0xFEFA in 16-bit mode => 262 edges
    do_write(3'd2, 12'h000, 8'h0E);
    do_write(3'd4, 12'h000, 8'h02);
    edges(6);
    check_irq("R2 16-bit mode ignores short wrap", 1'b0);
    edges(255);
    check_irq("R2 16-bit before wrap", 1'b0);
    edges(1);
    check_irq("R2 16-bit long wrap", 1'b1);
    do_write(3'd4, 12'h000, 8'h00);
    check_irq("R3 ctrl write with enable 0 clears", 1'b0);
    edges(300);
    check_irq("R2 enable 0 stops counting", 1'b0);

    // random phase against the requirement model (R1..R9)
    for (int i = 0; i < 6000; i++) begin
      check_irq("R1/R4/R5/R6/R7 random irq", m_irq);
      check_bank("R9 random bank", m_bank);
      if ($urandom % 4 == 0) begin
        logic [2:0] s;
        logic [7:0] d;
        s = 3'($urandom % 8);
        d = 8'($urandom);
        if (s == 3'd2 || s == 3'd3) d[3:2] = 2'b11;
        if (s == 3'd4 && ($urandom % 3 != 0)) d[1] = 1'b1;
        wr_en   = 1'b1;
        wr_addr = {s, 12'($urandom)};
        wr_data = d;
      end else begin
        wr_en = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    wr_en = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule